// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Processor Core

This core is a 16-bit processor whose only operation is "subtract and branch if the result is not positive". Each instruction is three consecutive memory words: a source address, a target address and a jump address. The core subtracts the source word from the target word, stores the difference back into the target, and either jumps or falls through to the next three-word group. There are no flags, no accumulator and no stack. Everything is done with memory words and a few internal address and operand registers.

After reset the core copies a boot image from a read-only port into RAM, one word at a time, starting at RAM address zero. It then waits for as long as the hold input is high, and starts executing at address zero. It stops for good when a taken branch targets the all-ones address.

Both memories are synchronous with a one-cycle read latency. An instruction takes six clock cycles: three to fetch its words, two to read the operands, and one to write back.

Top module: `subleq_core`

## Requirements
- R1: While `rst` is high, `halted_o` and `ram_we_o` are 0 and `rom_addr_o` is 0. After reset is released, the first RAM write goes to address 0.
- R2: After reset, ROM word i is written to RAM address i for every i from 0 to BOOT_WORDS-1, in increasing order, before any other RAM write.
- R3: After the copy finishes, no RAM write happens while `hold_i` is high. Execution starts at address 0 once `hold_i` is low.
- R4: For the instruction at PC, the words at PC, PC+1 and PC+2 are A, B and C. The core writes mem[B] − mem[A], modulo 2^16, to address B. This is the only RAM write for that instruction.
- R5: If the stored result has bit 15 set or is zero, the next PC is C.
- R6: If the stored result is otherwise (positive), the next PC is PC+3, modulo 2^16.
- R7: A taken branch whose C is 0xFFFF raises `halted_o`. `halted_o` then stays high and no further RAM write occurs until reset.
- R8: Subtraction overflow wraps silently. For example, 0x8000 − 0x0001 gives 0x7FFF, which counts as positive, so the branch is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | Holds the core between the boot copy and the first fetch |
| rom_addr_o | output | clog2(BOOT_WORDS) | Boot ROM read address |
| rom_data_i | input | 16 | Boot ROM data, valid one cycle after the address |
| ram_addr_o | output | 16 | RAM address for both reads and writes |
| ram_wdata_o | output | 16 | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_rdata_i | input | 16 | RAM read data, valid one cycle after the address |
| halted_o | output | 1 | High once execution has stopped at the halt address |

## Verification
The assertions assume the following about the memories:
- Both memories return the word for an address exactly one cycle after it is presented.
- `hold_i` changes only between clock edges.
- Reset is held for at least one edge at the start.

The bench drives its ROM and RAM models with that latency and changes `hold_i` and `rst` only on falling edges. Every program it loads keeps all of its addresses inside the boot image, so the instruction-level reference model and the RAM model cover the same words.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

  typedef enum logic [3:0] {
    ST_BOOT_RD,
    ST_BOOT_WR,
    ST_HOLD,
    ST_FETCH_A,
    ST_FETCH_B,
    ST_FETCH_C,
    ST_READ_A,
    ST_READ_B,
    ST_WRITE,
    ST_HALT
  } seq_st_t;

endpackage

// File: rtl/subleq_alu.sv
module subleq_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] minuend_i,
  input  logic [DW-1:0] subtrahend_i,
  output logic [DW-1:0] diff_o,
  output logic          le_zero_o
);

  // Wrapping two's-complement difference; sign bit or all-zero means <= 0.
  always_comb begin
    diff_o    = minuend_i - subtrahend_i;
    le_zero_o = diff_o[DW-1] | (diff_o == '0);
  end

endmodule

// File: rtl/subleq_seq.sv
module subleq_seq
  import subleq_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 16,
  parameter int BOOT_WORDS = 8192,
  parameter int RAW        = (BOOT_WORDS > 1) ? $clog2(BOOT_WORDS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold_i,
  output logic [RAW-1:0] rom_addr_o,
  input  logic [DW-1:0]  rom_data_i,
  output logic [AW-1:0]  ram_addr_o,
  output logic [DW-1:0]  ram_wdata_o,
  output logic           ram_we_o,
  input  logic [DW-1:0]  ram_rdata_i,
  input  logic [DW-1:0]  diff_i,
  input  logic           le_zero_i,
  output logic [DW-1:0]  opa_o,
  output logic           halted_o
);

  localparam logic [AW-1:0] HALT_ADDR = '1;
  localparam logic [AW-1:0] BOOT_LAST = AW'(BOOT_WORDS - 1);
  localparam logic [AW-1:0] STEP      = AW'(3);

  seq_st_t       st_q;
  logic [AW-1:0] pc_q, a_q, b_q, c_q;
  logic [DW-1:0] opa_q;
  logic          halted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_BOOT_RD;
      pc_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      c_q      <= '0;
      opa_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_BOOT_RD: st_q <= ST_BOOT_WR;
        ST_BOOT_WR: begin
          if (pc_q == BOOT_LAST) begin
            pc_q <= '0;
            st_q <= ST_HOLD;
          end else begin
            pc_q <= pc_q + 1'b1;
            st_q <= ST_BOOT_RD;
          end
        end
        ST_HOLD:    if (!hold_i) st_q <= ST_FETCH_A;
        ST_FETCH_A: st_q <= ST_FETCH_B;
        ST_FETCH_B: begin a_q <= AW'(ram_rdata_i); st_q <= ST_FETCH_C; end
        ST_FETCH_C: begin b_q <= AW'(ram_rdata_i); st_q <= ST_READ_A;  end
        ST_READ_A:  begin c_q <= AW'(ram_rdata_i); st_q <= ST_READ_B;  end
        ST_READ_B:  begin opa_q <= ram_rdata_i;    st_q <= ST_WRITE;   end
        ST_WRITE: begin
          if (le_zero_i) begin
            pc_q <= c_q;
            if (c_q == HALT_ADDR) begin
              halted_q <= 1'b1;
              st_q     <= ST_HALT;
            end else begin
              st_q <= ST_FETCH_A;
            end
          end else begin
            pc_q <= pc_q + STEP;
            st_q <= ST_FETCH_A;
          end
        end
        ST_HALT:    st_q <= ST_HALT;
        default:    st_q <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_FETCH_B:          ram_addr_o = pc_q + AW'(1);
      ST_FETCH_C:          ram_addr_o = pc_q + AW'(2);
      ST_READ_A:           ram_addr_o = a_q;
      ST_READ_B, ST_WRITE: ram_addr_o = b_q;
      default:             ram_addr_o = pc_q;
    endcase
    ram_we_o    = (st_q == ST_BOOT_WR) || (st_q == ST_WRITE);
    ram_wdata_o = (st_q == ST_BOOT_WR) ? rom_data_i : diff_i;
  end

  assign rom_addr_o = pc_q[RAW-1:0];
  assign opa_o      = opa_q;
  assign halted_o   = halted_q;

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o);

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> !ram_we_o);

  // R3
  hold_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && hold_i) |=> !ram_we_o);

  // R2
  boot_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BOOT_WR) |-> (ram_addr_o <= BOOT_LAST));

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WRITE && !le_zero_i) |=> (pc_q == $past(pc_q) + STEP));

endmodule

// File: rtl/subleq_core.sv
module subleq_core #(
  parameter int DW         = 16,
  parameter int AW         = 16,
  parameter int BOOT_WORDS = 8192,
  parameter int RAW        = (BOOT_WORDS > 1) ? $clog2(BOOT_WORDS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold_i,
  output logic [RAW-1:0] rom_addr_o,
  input  logic [DW-1:0]  rom_data_i,
  output logic [AW-1:0]  ram_addr_o,
  output logic [DW-1:0]  ram_wdata_o,
  output logic           ram_we_o,
  input  logic [DW-1:0]  ram_rdata_i,
  output logic           halted_o
);

  logic [DW-1:0] diff;
  logic [DW-1:0] opa;
  logic          le_zero;

  subleq_alu #(.DW(DW)) alu_i (
    .minuend_i    (ram_rdata_i),
    .subtrahend_i (opa),
    .diff_o       (diff),
    .le_zero_o    (le_zero)
  );

  subleq_seq #(
    .DW(DW), .AW(AW), .BOOT_WORDS(BOOT_WORDS), .RAW(RAW)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .hold_i      (hold_i),
    .rom_addr_o  (rom_addr_o),
    .rom_data_i  (rom_data_i),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_we_o    (ram_we_o),
    .ram_rdata_i (ram_rdata_i),
    .diff_i      (diff),
    .le_zero_i   (le_zero),
    .opa_o       (opa),
    .halted_o    (halted_o)
  );

endmodule

// File: tb/subleq_core_tb_top.sv
module subleq_core_tb_top;

  localparam int BW  = 32;
  localparam int RAW = $clog2(BW);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           hold_i = 1'b0;
  logic [RAW-1:0] rom_addr_o;
  logic [15:0]    rom_q;
  logic [15:0]    ram_addr_o, ram_wdata_o, ram_q;
  logic           ram_we_o, halted_o;

  logic [15:0] rom [BW];
  logic [15:0] ram [64];

  int errors = 0;
  int checks = 0;
  int wr_seen = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  subleq_core #(.BOOT_WORDS(BW)) dut_i (
    .clk(clk), .rst(rst), .hold_i(hold_i),
    .rom_addr_o(rom_addr_o), .rom_data_i(rom_q),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .ram_we_o(ram_we_o), .ram_rdata_i(ram_q),
    .halted_o(halted_o)
  );

  always @(posedge clk) begin
    rom_q <= rom[rom_addr_o];
    if (ram_we_o) ram[ram_addr_o[5:0]] <= ram_wdata_o;
    ram_q <= ram[ram_addr_o[5:0]];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare every RAM write as it appears.
  always @(negedge clk) begin
    if (!rst && ram_we_o) begin
      wr_seen++;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected write actual=%h expected=none", {ram_addr_o, ram_wdata_o});
      end else begin
        check(tag_q.pop_front(), {ram_addr_o, ram_wdata_o}, exp_q.pop_front());
      end
    end
  end

  // Driver: boot items (R2) and an instruction-level reference run (R4..R8).
  task automatic drive(input string tag);
    logic [15:0] m [BW];
    logic [15:0] pc, a, b, c, r;
    exp_q.delete(); tag_q.delete();
    for (int i = 0; i < BW; i++) begin
      m[i] = rom[i];
      exp_q.push_back({16'(i), rom[i]});
      tag_q.push_back("R2 boot copy");
    end
    pc = 16'h0000;
    for (int s = 0; s < 200; s++) begin
      a = m[pc[4:0]]; b = m[pc[4:0] + 5'd1]; c = m[pc[4:0] + 5'd2];
      r = m[b[4:0]] - m[a[4:0]];
      m[b[4:0]] = r;
      exp_q.push_back({b, r});
      tag_q.push_back(tag);
      if (r[15] || r == 16'h0) begin
        if (c == 16'hFFFF) break;
        pc = c;
      end else pc = pc + 16'd3;
    end
  endtask

  task automatic put(input int base, input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    rom[base] = x; rom[base+1] = y; rom[base+2] = z;
  endtask

  task automatic clear_rom();
    for (int i = 0; i < BW; i++) rom[i] = 16'h0000;
  endtask

  task automatic run(input string tag, input bit use_hold);
    int t;
    @(negedge clk);
    rst = 1'b1; hold_i = use_hold;
    drive(tag);
    repeat (3) @(negedge clk);
    check("R1 reset halted", 32'(halted_o), 32'd0);
    check("R1 reset we", 32'(ram_we_o), 32'd0);
    check("R1 reset rom addr", 32'(rom_addr_o), 32'd0);
    wr_seen = 0;
    rst = 1'b0;
    if (use_hold) begin
      t = 0;
      while (wr_seen < BW && t < 1000) begin @(negedge clk); t++; end
      repeat (25) @(negedge clk);
      check("R3 no write during hold", 32'(wr_seen), 32'(BW));
      hold_i = 1'b0;
    end
    t = 0;
    while (!halted_o && t < 5000) begin @(negedge clk); t++; end
    check({"R7 halted ", tag}, 32'(halted_o), 32'd1);
    check({"R5 R6 all writes seen ", tag}, 32'(exp_q.size()), 32'd0);
    t = wr_seen;
    repeat (10) @(negedge clk);
    check("R7 halted sticky", 32'(halted_o), 32'd1);
    check("R7 no write after halt", 32'(wr_seen), 32'(t));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ram[i] = 16'h0000;
    // P1: 10-3=7 positive, falls through (R6); 7-7=0 taken to halt (R5, R7).
    clear_rom();
    put(0, 16'd20, 16'd21, 16'd3);
    put(3, 16'd22, 16'd21, 16'hFFFF);
    rom[20] = 16'd3; rom[21] = 16'd10; rom[22] = 16'd7;
    run("R4 R6 P1", 1'b0);
    // P2: countdown loop, taken branch to a non-halt target (R5).
    clear_rom();
    put(0, 16'd20, 16'd21, 16'd6);
    put(3, 16'd22, 16'd22, 16'd0);
    put(6, 16'd23, 16'd23, 16'hFFFF);
    rom[20] = 16'd1; rom[21] = 16'd3;
    run("R4 R5 P2", 1'b0);
    // P3: negative result taken (R5); 0x8000-1 wraps to 0x7FFF, not taken (R8).
    clear_rom();
    put(0, 16'd20, 16'd21, 16'd6);
    put(6, 16'd22, 16'd23, 16'd9);
    put(9, 16'd24, 16'd24, 16'hFFFF);
    rom[20] = 16'd9; rom[21] = 16'd5; rom[22] = 16'd1; rom[23] = 16'h8000;
    run("R4 R8 P3", 1'b0);
    // P1 again with the hold input asserted after the copy (R3).
    clear_rom();
    put(0, 16'd20, 16'd21, 16'd3);
    put(3, 16'd22, 16'd21, 16'hFFFF);
    rom[20] = 16'd3; rom[21] = 16'd10; rom[22] = 16'd7;
    run("R3 R4 hold", 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule